// File: doc/BRIEF.md
# Signed Integer to Single-Precision Float Converter

This block turns a two's complement signed integer into the single-precision binary floating-point word of exactly the same value. The sign comes straight from the top input bit. The magnitude is formed in an unsigned path as wide as the input, so that the most negative input still has a magnitude that fits. A priority encoder finds the highest set bit of the magnitude. That position, plus the exponent bias, gives the biased exponent. A logarithmic left shifter then moves the leading one to the top, where it is dropped to leave the fraction field.

Every magnitude of a 16-bit input has fewer significant bits than the 24-bit significand, so the result is always exact and there is no rounding stage. The datapath is purely combinational. A parameter selects an optional output register. When the register is present, a result is captured only in a cycle where `in_valid` is high, and it appears one cycle later together with `out_valid`.

Top module: `i2f_convert`

## Requirements
- R1: For every nonzero input, output bit 31 (sign) equals input bit 15.
- R2: For every one of the 65536 inputs, the output word encodes exactly the numeric value of the input. Bits 30:23 hold the biased exponent, bits 22:0 hold the fraction, and the bias is 127.
- R3: For every nonzero input, the exponent field lies between 127 and 142 inclusive. Fraction bits 7:0 are always zero.
- R4: Input 0x0000 gives output 0x00000000.
- R5: Input 0x8000 (-32768) gives output 0xC7000000.
- R6: With the output register enabled (the default), `out_valid` equals `in_valid` delayed by one clock. In a cycle where `in_valid` is low, `out_float` keeps its previous value.
- R7: While `rst_n` is low, `out_valid` is 0 and `out_float` is 0x00000000.
- R8: Inputs at the ends of the range convert exactly: 0xFFFF gives 0xBF800000, 0x7FFF gives 0x46FFFE00, and 0x0001 gives 0x3F800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_int` in this cycle |
| in_int | input | 16 | Two's complement integer operand |
| out_valid | output | 1 | High when `out_float` holds a new result |
| out_float | output | 32 | Single-precision result |

## Verification
The bench sweeps all 65536 inputs back to back. It compares each output against an encoding derived from the integer's real value, so every shift amount and every exponent is covered.

Several corner cases are checked one by one:
- The most negative input catches a magnitude path one bit too narrow, which would yield zero or a positive value.
- Zero catches a design that emits the bias as the exponent instead of an all-zero word.
- Minus one and 0x7FFF catch shift-amount errors that are off by one, which show up as a wrong exponent or a stray fraction bit.
- A stretch with `in_valid` low while the input keeps changing shows whether the register wrongly loads unqualified data.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
   localparam int SP_EXP_W  = 8;
   localparam int SP_FRAC_W = 23;
   localparam int SP_BIAS   = 127;

   typedef struct packed {
      logic                 sign;
      logic [SP_EXP_W-1:0]  exponent;
      logic [SP_FRAC_W-1:0] fraction;
   } sp_word_t;
endpackage

// File: rtl/i2f_lead_one.sv
module i2f_lead_one #(
   parameter int W    = 16,
   localparam int PW  = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [PW-1:0] pos,
   output logic          found
);
   initial begin
      assert (W >= 2) else $error("i2f_lead_one: W must be at least 2");
   end

   always_comb begin
      pos   = '0;
      found = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) begin
            pos   = PW'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/i2f_norm_shift.sv
module i2f_norm_shift #(
   parameter int W    = 16,
   localparam int SW  = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  dout
);
   logic [W-1:0] stage [0:SW];

   assign stage[0] = din;

   generate
      for (genvar k = 0; k < SW; k++) begin : g_stage
         assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
      end
   endgenerate

   assign dout = stage[SW];
endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
   import i2f_pkg::*;
#(
   parameter int IN_W    = 16,
   parameter int EXP_W   = SP_EXP_W,
   parameter int FRAC_W  = SP_FRAC_W,
   parameter int BIAS    = SP_BIAS,
   parameter bit REG_OUT = 1'b1,
   localparam int OUT_W  = 1 + EXP_W + FRAC_W,
   localparam int PW     = $clog2(IN_W),
   localparam int PAD    = FRAC_W - (IN_W - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_int,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_float
);
   initial begin
      assert (IN_W >= 2) else $error("i2f_convert: IN_W too small");
      assert (PAD >= 0) else $error("i2f_convert: significand too narrow for exact result");
      assert (BIAS + IN_W - 1 < (1 << EXP_W) - 1) else $error("i2f_convert: exponent field too narrow");
   end

   logic              neg;
   logic [IN_W-1:0]   mag;
   logic [PW-1:0]     lead_pos;
   logic              nonzero;
   logic [PW-1:0]     shift_amt;
   logic [IN_W-1:0]   normed;
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic [OUT_W-1:0]  result;

   assign neg = in_int[IN_W-1];
   assign mag = neg ? (~in_int + IN_W'(1)) : in_int;

   i2f_lead_one #(.W(IN_W)) u_lead (
      .vec   (mag),
      .pos   (lead_pos),
      .found (nonzero)
   );

   assign shift_amt = PW'(IN_W - 1) - lead_pos;

   i2f_norm_shift #(.W(IN_W)) u_shift (
      .din  (mag),
      .amt  (shift_amt),
      .dout (normed)
   );

   assign exp_f = EXP_W'(BIAS) + EXP_W'(lead_pos);

   generate
      if (PAD > 0) begin : g_pad
         assign frac_f = {normed[IN_W-2:0], {PAD{1'b0}}};
      end else begin : g_nopad
         assign frac_f = normed[IN_W-2:0];
      end
   endgenerate

   assign result = nonzero ? {neg, exp_f, frac_f} : '0;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_float <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) out_float <= result;
            end
         end
      end else begin : g_comb
         assign out_valid = in_valid;
         assign out_float = result;
      end
   endgenerate
endmodule

// File: rtl/i2f_convert_chk.sv
module i2f_convert_chk #(
   parameter int IN_W    = 16,
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int BIAS    = 127,
   parameter bit REG_OUT = 1'b1,
   localparam int OUT_W  = 1 + EXP_W + FRAC_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [IN_W-1:0]  in_int,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_float
);
   generate
      if (REG_OUT) begin : g_seq
         AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_int != '0) |=> out_float[OUT_W-1] == $past(in_int[IN_W-1])); // R1
         AST_LOW_FRAC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_float[7:0] == 8'h00); // R3
         AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_float != '0) |->
               (out_float[OUT_W-2 -: EXP_W] >= EXP_W'(BIAS) &&
                out_float[OUT_W-2 -: EXP_W] <= EXP_W'(BIAS + IN_W - 1))); // R3
         AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> ((out_float == '0) == ($past(in_int) == '0))); // R4
         AST_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_int == {1'b1, {(IN_W-1){1'b0}}}) |=> out_float == 32'hC700_0000); // R5
         AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R6
         AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(out_float))); // R6
      end
   endgenerate
endmodule

bind i2f_convert i2f_convert_chk #(
   .IN_W(IN_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
   .out_valid(out_valid), .out_float(out_float)
);

// File: tb/i2f_convert_bench.sv
module i2f_convert_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_int = '0;
   logic        out_valid;
   logic [31:0] out_float;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   i2f_convert u_i2f_convert (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
      .out_valid(out_valid), .out_float(out_float)
   );

   function automatic logic [31:0] ref_word(logic [15:0] v);
      real r;
      logic [63:0] b;
      logic [10:0] e;
      r = real'($signed(v));
      b = $realtobits(r);
      e = b[62:52] - 11'd896;
      if (v == 16'h0000) return 32'h0;
      return {b[63], e[7:0], b[51:29]};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic convert_one(string req, logic [15:0] v, logic [31:0] expv);
      @(negedge clk);
      in_int = v;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, out_float, expv);
      check({req, " valid"}, {31'd0, out_valid}, 32'd1);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      in_int = 16'h1234;
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      check("R7 reset data", out_float, 32'h0);
      check("R7 reset valid", {31'd0, out_valid}, 32'd0);
      rst_n = 1'b1;
      in_valid = 1'b0;

      convert_one("R4 zero", 16'h0000, 32'h0000_0000);
      convert_one("R5 most negative", 16'h8000, 32'hC700_0000);
      convert_one("R8 minus one", 16'hFFFF, 32'hBF80_0000);
      convert_one("R8 max positive", 16'h7FFF, 32'h46FF_FE00);
      convert_one("R8 one", 16'h0001, 32'h3F80_0000);

      // R6: idle cycles must not reload the register while the input moves
      @(negedge clk);
      in_int = 16'h4321;
      @(negedge clk);
      in_int = 16'h8001;
      @(negedge clk);
      check("R6 hold data", out_float, 32'h3F80_0000);
      check("R6 hold valid", {31'd0, out_valid}, 32'd0);

      // R2 R1 R3: exhaustive back-to-back sweep
      for (int i = 0; i < 65536; i++) begin
         logic [15:0] prev;
         @(negedge clk);
         if (i > 0) begin
            prev = 16'(i - 1);
            check("R2 sweep", out_float, ref_word(prev));
            if (prev != 16'h0) begin
               checks++;
               if (out_float[31] !== prev[15] || out_float[30:23] < 8'd127 || out_float[30:23] > 8'd142) begin
                  errors++;
                  $display("FAIL R1/R3 sign/exponent actual=%h expected sign=%b exp 127..142", out_float, prev[15]);
               end
            end
         end
         in_int = 16'(i);
         in_valid = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 sweep last", out_float, ref_word(16'hFFFF));
      @(negedge clk);
      check("R6 valid drop", {31'd0, out_valid}, 32'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule